// File: doc/BRIEF.md
# ULPI PHY Status Byte Generator

This block lives on the PHY side of a ULPI link. Each cycle it gathers the PHY's status inputs into one status byte: the two line-state bits, the VBUS comparator flags, the receive-active, receive-error and host-disconnect flags, and the ID pin level. When the byte differs from the last one sent, the block takes the shared 8-bit data bus and sends the new byte to the link. A B-valid edge whose enable is set also causes a byte, with the top bit marked.

The bus is taken by raising DIR, followed by one cycle with the bus undriven before the first byte. The bus is kept while a USB receive is active. During that time, received packet bytes go out with NXT high, and status bytes fill the cycles between them with NXT low. When nothing is left to send and no receive is active, DIR drops, followed by one cycle in which DIR cannot rise again.

A separate qualifier asserts an ID-valid output only after the ID pull-up enable has been held for a settle time that is set by a parameter.

Top module: `ulpi_stat_gen`

## Requirements
- R1: After synchronous reset, `dir_o`, `data_oe_o`, `nxt_o`, `data_o` and `id_valid_o` are all 0.
- R2: Status byte layout: bit 7 alternate-interrupt flag, bit 6 ID pin, bits 5:4 receive event, bits 3:2 VBUS code, bits 1:0 line state. A status byte is sent only with `dir_o` high, `data_oe_o` high and `nxt_o` low.
- R3: VBUS code: 11 when the VBUS-valid flag is set; otherwise 10 when session-valid is set; otherwise 01 when session-end is clear; otherwise 00.
- R4: Receive-event code: 10 when host disconnect is flagged; otherwise 11 when receive is active with an error; 01 when receive is active without an error; 00 otherwise.
- R5: When bits 6:0 of the current status differ from the last byte sent, or an alternate interrupt is pending, `dir_o` rises at the next edge with the bus undriven. The status byte follows one cycle later. With no change and no receive active, `dir_o` stays low.
- R6: After a status byte, if no receive is active and nothing has changed, `dir_o` falls at the next edge with the bus undriven. `dir_o` then stays low for at least one more cycle.
- R7: While the bus is held, a change in each of several consecutive cycles produces a status byte in each following cycle, each carrying its own cycle's fields. No update is lost.
- R8: While the bus is held, a received byte flagged valid is driven with `nxt_o` high, one cycle later. If a received byte and a status change fall in the same cycle, the received byte goes first and the status byte follows in the next free cycle. Received bytes flagged while the bus is not held and no receive is active are ignored, and `dir_o` stays low.
- R9: A B-valid rising edge with its enable set, or a falling edge with its enable set, causes a status byte with bit 7 set. The following byte has bit 7 clear. An edge whose enable is clear causes no byte.
- R10: `id_valid_o` rises exactly `ID_WAIT_CYCLES` edges after `id_pullup_i` goes high, provided it stays high. It is low in the cycle after any edge at which `id_pullup_i` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| line_st_i | input | 2 | Line-state bits |
| sess_end_i | input | 1 | VBUS below session-end comparator flag |
| sess_vld_i | input | 1 | Session-valid comparator flag |
| vbus_vld_i | input | 1 | VBUS-valid comparator flag |
| rx_active_i | input | 1 | USB receive in progress |
| rx_error_i | input | 1 | Receive error flag |
| host_disc_i | input | 1 | Host disconnect detected |
| id_pin_i | input | 1 | ID pin level |
| id_pullup_i | input | 1 | ID pull-up enable |
| bvalid_i | input | 1 | B-session valid level |
| bvalid_rise_en_i | input | 1 | Flag B-valid rising edges |
| bvalid_fall_en_i | input | 1 | Flag B-valid falling edges |
| rx_byte_valid_i | input | 1 | Received packet byte present |
| rx_byte_i | input | 8 | Received packet byte |
| dir_o | output | 1 | Bus direction, high when the PHY owns the bus |
| nxt_o | output | 1 | High when the driven byte is packet data |
| data_o | output | 8 | Data bus value driven by the PHY |
| data_oe_o | output | 1 | PHY drives the data bus |
| id_valid_o | output | 1 | ID bit has settled |

## Verification
Two functions can fall in the same cycle: a received packet byte and a status change. The bench provokes this by raising `rx_byte_valid_i` and changing the line state in the same cycle while a receive holds the bus. It expects the packet byte with NXT high first and the new status byte with NXT low in the very next cycle. A second overlap is a B-valid edge together with a line-state change. Here a single status byte must carry both bit 7 and the new line bits.

// File: rtl/ulpi_stat_pkg.sv
package ulpi_stat_pkg;

    localparam int STAT_W = 8;

    typedef enum logic [1:0] {
        BUS_IDLE = 2'd0,
        BUS_TURN = 2'd1,
        BUS_OWN  = 2'd2,
        BUS_REL  = 2'd3
    } bus_state_e;

    // Fields that are compared against the last byte sent
    typedef struct packed {
        logic       id;
        logic [1:0] rx_evt;
        logic [1:0] vbus;
        logic [1:0] line;
    } stat_fields_t;

    typedef struct packed {
        logic         alt;
        stat_fields_t f;
    } stat_byte_t;

    function automatic logic [1:0] enc_vbus(input logic s_end, input logic s_vld,
                                            input logic v_vld);
        if (v_vld)       return 2'b11;
        else if (s_vld)  return 2'b10;
        else if (!s_end) return 2'b01;
        else             return 2'b00;
    endfunction

    function automatic logic [1:0] enc_rx_evt(input logic act, input logic err,
                                              input logic disc);
        if (disc)           return 2'b10;
        else if (act & err) return 2'b11;
        else if (act)       return 2'b01;
        else                return 2'b00;
    endfunction

endpackage

// File: rtl/ulpi_stat_pack.sv
module ulpi_stat_pack
    import ulpi_stat_pkg::*;
(
    input  logic [1:0]   line_st_i,
    input  logic         sess_end_i,
    input  logic         sess_vld_i,
    input  logic         vbus_vld_i,
    input  logic         rx_active_i,
    input  logic         rx_error_i,
    input  logic         host_disc_i,
    input  logic         id_pin_i,
    output stat_fields_t fields_o
);

    always_comb begin
        fields_o.line   = line_st_i;
        fields_o.vbus   = enc_vbus(sess_end_i, sess_vld_i, vbus_vld_i);
        fields_o.rx_evt = enc_rx_evt(rx_active_i, rx_error_i, host_disc_i);
        fields_o.id     = id_pin_i;
    end

endmodule

// File: rtl/ulpi_id_qual.sv
module ulpi_id_qual #(
    parameter int WAIT_CYCLES = 10_000_000
) (
    input  logic clk,
    input  logic rst,
    input  logic pullup_i,
    output logic valid_o
);

    localparam int CNT_W = $clog2(WAIT_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(WAIT_CYCLES);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || !pullup_i) begin
            cnt_q <= '0;
        end else if (cnt_q != CNT_MAX) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign valid_o = (cnt_q == CNT_MAX);

endmodule

// File: rtl/ulpi_stat_bus.sv
module ulpi_stat_bus
    import ulpi_stat_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  stat_fields_t      fields_i,
    input  logic              bvalid_i,
    input  logic              rise_en_i,
    input  logic              fall_en_i,
    input  logic              rx_active_i,
    input  logic              rx_byte_valid_i,
    input  logic [STAT_W-1:0] rx_byte_i,
    output logic              dir_o,
    output logic              oe_o,
    output logic              nxt_o,
    output logic [STAT_W-1:0] data_o
);

    bus_state_e        state_q, state_d;
    stat_fields_t      last_q;
    stat_byte_t        tx_byte;
    logic              bvalid_q;
    logic              alt_pend_q;
    logic              edge_hit;
    logic              alt_now;
    logic              change;
    logic              load_stat;
    logic              load_data;
    logic              dir_q, oe_q, nxt_q;
    logic [STAT_W-1:0] data_q;

    // Enabled B-valid edge detection
    assign edge_hit = (bvalid_i & ~bvalid_q & rise_en_i) |
                      (~bvalid_i & bvalid_q & fall_en_i);
    assign alt_now  = alt_pend_q | edge_hit;

    always_comb begin
        tx_byte.alt = alt_now;
        tx_byte.f   = fields_i;
    end

    assign change = (fields_i != last_q) | alt_now;

    // Bus ownership sequencing
    always_comb begin
        state_d   = state_q;
        load_stat = 1'b0;
        load_data = 1'b0;
        unique case (state_q)
            BUS_IDLE: begin
                if (change || rx_active_i) state_d = BUS_TURN;
            end
            BUS_TURN: begin
                state_d = BUS_OWN;
                if (rx_byte_valid_i) load_data = 1'b1;
                else                 load_stat = 1'b1;
            end
            BUS_OWN: begin
                if (rx_byte_valid_i)            load_data = 1'b1;
                else if (rx_active_i || change) load_stat = 1'b1;
                else                            state_d   = BUS_REL;
            end
            BUS_REL: state_d = BUS_IDLE;
            default: state_d = BUS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        bvalid_q <= bvalid_i;
        if (rst) begin
            state_q    <= BUS_IDLE;
            last_q     <= '0;
            alt_pend_q <= 1'b0;
            dir_q      <= 1'b0;
            oe_q       <= 1'b0;
            nxt_q      <= 1'b0;
            data_q     <= '0;
        end else begin
            state_q <= state_d;
            dir_q   <= (state_d == BUS_TURN) || (state_d == BUS_OWN);
            oe_q    <= load_stat | load_data;
            nxt_q   <= load_data;
            if (load_data)      data_q <= rx_byte_i;
            else if (load_stat) data_q <= tx_byte;
            else                data_q <= '0;
            if (load_stat) begin
                last_q     <= fields_i;
                alt_pend_q <= 1'b0;
            end else if (edge_hit) begin
                alt_pend_q <= 1'b1;
            end
        end
    end

    assign dir_o  = dir_q;
    assign oe_o   = oe_q;
    assign nxt_o  = nxt_q;
    assign data_o = data_q;

endmodule

// File: rtl/ulpi_stat_gen.sv
module ulpi_stat_gen
    import ulpi_stat_pkg::*;
#(
    parameter int ID_WAIT_CYCLES = 10_000_000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] line_st_i,
    input  logic       sess_end_i,
    input  logic       sess_vld_i,
    input  logic       vbus_vld_i,
    input  logic       rx_active_i,
    input  logic       rx_error_i,
    input  logic       host_disc_i,
    input  logic       id_pin_i,
    input  logic       id_pullup_i,
    input  logic       bvalid_i,
    input  logic       bvalid_rise_en_i,
    input  logic       bvalid_fall_en_i,
    input  logic       rx_byte_valid_i,
    input  logic [7:0] rx_byte_i,
    output logic       dir_o,
    output logic       nxt_o,
    output logic [7:0] data_o,
    output logic       data_oe_o,
    output logic       id_valid_o
);

    stat_fields_t cur_fields;

    ulpi_stat_pack pack_i (
        .line_st_i   (line_st_i),
        .sess_end_i  (sess_end_i),
        .sess_vld_i  (sess_vld_i),
        .vbus_vld_i  (vbus_vld_i),
        .rx_active_i (rx_active_i),
        .rx_error_i  (rx_error_i),
        .host_disc_i (host_disc_i),
        .id_pin_i    (id_pin_i),
        .fields_o    (cur_fields)
    );

    ulpi_stat_bus bus_i (
        .clk             (clk),
        .rst             (rst),
        .fields_i        (cur_fields),
        .bvalid_i        (bvalid_i),
        .rise_en_i       (bvalid_rise_en_i),
        .fall_en_i       (bvalid_fall_en_i),
        .rx_active_i     (rx_active_i),
        .rx_byte_valid_i (rx_byte_valid_i),
        .rx_byte_i       (rx_byte_i),
        .dir_o           (dir_o),
        .oe_o            (data_oe_o),
        .nxt_o           (nxt_o),
        .data_o          (data_o)
    );

    ulpi_id_qual #(.WAIT_CYCLES(ID_WAIT_CYCLES)) idq_i (
        .clk      (clk),
        .rst      (rst),
        .pullup_i (id_pullup_i),
        .valid_o  (id_valid_o)
    );

endmodule

// File: rtl/ulpi_stat_gen_chk.sv
module ulpi_stat_gen_chk
    import ulpi_stat_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic [1:0] line_st_i,
    input logic       sess_end_i,
    input logic       sess_vld_i,
    input logic       vbus_vld_i,
    input logic       rx_active_i,
    input logic       rx_error_i,
    input logic       host_disc_i,
    input logic       id_pin_i,
    input logic       id_pullup_i,
    input logic [7:0] rx_byte_i,
    input logic       dir_o,
    input logic       nxt_o,
    input logic [7:0] data_o,
    input logic       data_oe_o,
    input logic       id_valid_o
);

    a_r2_drive_needs_dir: assert property (@(posedge clk) disable iff (rst)
        data_oe_o |-> dir_o);

    a_r2_line_id_fields: assert property (@(posedge clk) disable iff (rst)
        (data_oe_o && !nxt_o) |->
            (data_o[1:0] == $past(line_st_i) && data_o[6] == $past(id_pin_i)));

    a_r3_vbus_field: assert property (@(posedge clk) disable iff (rst)
        (data_oe_o && !nxt_o) |->
            data_o[3:2] == enc_vbus($past(sess_end_i), $past(sess_vld_i), $past(vbus_vld_i)));

    a_r4_event_field: assert property (@(posedge clk) disable iff (rst)
        (data_oe_o && !nxt_o) |->
            data_o[5:4] == enc_rx_evt($past(rx_active_i), $past(rx_error_i), $past(host_disc_i)));

    a_r5_turn_undriven: assert property (@(posedge clk) disable iff (rst)
        $rose(dir_o) |-> !data_oe_o);

    a_r5_drive_after_turn: assert property (@(posedge clk) disable iff (rst)
        $rose(dir_o) |=> data_oe_o);

    a_r6_release_undriven: assert property (@(posedge clk) disable iff (rst)
        $fell(dir_o) |-> (!data_oe_o && !nxt_o));

    a_r6_release_gap: assert property (@(posedge clk) disable iff (rst)
        $fell(dir_o) |=> !dir_o);

    a_r8_data_byte: assert property (@(posedge clk) disable iff (rst)
        nxt_o |-> (data_oe_o && data_o == $past(rx_byte_i)));

    a_r10_id_drop: assert property (@(posedge clk) disable iff (rst)
        !id_pullup_i |=> !id_valid_o);

endmodule

bind ulpi_stat_gen ulpi_stat_gen_chk chk_i (.*);

// File: tb/ulpi_stat_gen_tb_top.sv
`timescale 1ns/1ps
module ulpi_stat_gen_tb_top;

    localparam int ID_WAIT = 16;

    logic       clk = 1'b0;
    logic       rst;
    logic [1:0] line_st;
    logic       sess_end, sess_vld, vbus_vld;
    logic       rx_active, rx_error, host_disc;
    logic       id_pin, id_pullup;
    logic       bvalid, rise_en, fall_en;
    logic       rx_valid;
    logic [7:0] rx_byte;
    logic       dir, nxt, oe, id_valid;
    logic [7:0] data;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    ulpi_stat_gen #(.ID_WAIT_CYCLES(ID_WAIT)) dut_i (
        .clk(clk), .rst(rst), .line_st_i(line_st),
        .sess_end_i(sess_end), .sess_vld_i(sess_vld), .vbus_vld_i(vbus_vld),
        .rx_active_i(rx_active), .rx_error_i(rx_error), .host_disc_i(host_disc),
        .id_pin_i(id_pin), .id_pullup_i(id_pullup), .bvalid_i(bvalid),
        .bvalid_rise_en_i(rise_en), .bvalid_fall_en_i(fall_en),
        .rx_byte_valid_i(rx_valid), .rx_byte_i(rx_byte),
        .dir_o(dir), .nxt_o(nxt), .data_o(data), .data_oe_o(oe),
        .id_valid_o(id_valid)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // Drive VBUS flags for level k (0..3)
    task automatic set_vbus(input int k);
        sess_end = (k == 0);
        sess_vld = (k >= 2);
        vbus_vld = (k == 3);
    endtask

    // Inputs already changed; expect full acquire / byte / release sequence
    task automatic expect_update(input logic [7:0] exp, input string req);
        tick();
        check(dir && !oe, "R5 turnaround", {oe, dir}, 32'h1);
        tick();
        check(oe && !nxt && data == exp, req, data, exp);
        tick();
        check(!dir && !oe, "R6 release", {oe, dir}, 32'h0);
        tick();
        check(!dir, "R6 release gap", dir, 0);
    endtask

    task automatic expect_quiet(input string req);
        bit stayed = 1'b1;
        for (int i = 0; i < 4; i++) begin
            tick();
            if (dir) stayed = 1'b0;
        end
        check(stayed, req, dir, 0);
    endtask

    initial begin
        rst = 1'b1; line_st = 2'b00; set_vbus(0);
        rx_active = 0; rx_error = 0; host_disc = 0;
        id_pin = 0; id_pullup = 0; bvalid = 0; rise_en = 0; fall_en = 0;
        rx_valid = 0; rx_byte = 8'h00;
        repeat (3) tick();
        rst = 1'b0;
        tick();
        check(!dir && !oe && !nxt && data == 8'h00 && !id_valid, "R1 reset state",
              {id_valid, nxt, oe, dir, data}, 0);
        expect_quiet("R5 no change keeps dir low");

        // Sweep line state, VBUS level and ID pin (R2, R3)
        begin
            logic [7:0] prev = 8'h00;
            for (int id = 0; id < 2; id++)
                for (int k = 0; k < 4; k++)
                    for (int l = 0; l < 4; l++) begin
                        logic [7:0] exp;
                        exp = 8'((id << 6) | (k << 2) | l);
                        if (exp != prev) begin
                            line_st = 2'(l); set_vbus(k); id_pin = id[0];
                            expect_update(exp, "R2 R3 sweep byte");
                            prev = exp;
                        end
                    end
        end

        // Back to zero, then host disconnect (R4)
        line_st = 2'b00; set_vbus(0); id_pin = 0;
        expect_update(8'h00, "R2 return to zero");
        host_disc = 1;
        expect_update(8'h20, "R4 host disconnect code");
        host_disc = 0;
        expect_update(8'h00, "R4 idle code");

        // Receive sequence (R4, R7, R8)
        rx_active = 1;
        tick();
        check(dir && !oe, "R5 turnaround for receive", {oe, dir}, 32'h1);
        tick();
        check(oe && !nxt && data == 8'h10, "R4 receive active code", data, 8'h10);
        tick();
        check(dir && oe && !nxt && data == 8'h10, "R8 bus held during receive", data, 8'h10);
        rx_valid = 1; rx_byte = 8'hA5;
        tick();
        check(nxt && oe && data == 8'hA5, "R8 data byte with nxt", data, 8'hA5);
        rx_byte = 8'h3C; line_st = 2'b10;
        tick();
        check(nxt && data == 8'h3C, "R8 collision data first", data, 8'h3C);
        rx_valid = 0;
        tick();
        check(!nxt && oe && data == 8'h12, "R8 collision status next", data, 8'h12);
        line_st = 2'b01;
        tick();
        check(!nxt && data == 8'h11, "R7 back-to-back 1", data, 8'h11);
        line_st = 2'b11;
        tick();
        check(!nxt && data == 8'h13, "R7 back-to-back 2", data, 8'h13);
        rx_error = 1;
        tick();
        check(!nxt && data == 8'h33, "R4 receive error code", data, 8'h33);
        rx_active = 0; rx_error = 0; line_st = 2'b00;
        tick();
        check(oe && !nxt && data == 8'h00, "R7 final status before release", data, 8'h00);
        tick();
        check(!dir && !oe, "R6 release after receive", {oe, dir}, 0);
        tick();

        // Received byte while idle is ignored (R8)
        rx_valid = 1; rx_byte = 8'h77;
        expect_quiet("R8 idle rx byte ignored");
        rx_valid = 0;

        // Alternate interrupt (R9)
        rise_en = 1; bvalid = 1;
        expect_update(8'h80, "R9 enabled rise sets bit7");
        bvalid = 0;
        expect_quiet("R9 disabled fall no byte");
        rise_en = 0; fall_en = 1; bvalid = 1;
        expect_quiet("R9 disabled rise no byte");
        bvalid = 0;
        expect_update(8'h80, "R9 enabled fall sets bit7");
        rise_en = 1; bvalid = 1; line_st = 2'b01;
        expect_update(8'h81, "R9 edge with field change");
        line_st = 2'b00;
        expect_update(8'h00, "R9 bit7 cleared next byte");

        // ID settle time (R10)
        id_pullup = 1;
        begin
            bit early = 1'b0;
            for (int i = 1; i < ID_WAIT; i++) begin
                tick();
                if (id_valid) early = 1'b1;
            end
            check(!early, "R10 id valid not early", early, 0);
        end
        tick();
        check(id_valid, "R10 id valid at settle time", id_valid, 1);
        id_pullup = 0;
        tick();
        check(!id_valid, "R10 id valid drops", id_valid, 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule